// File: doc/BRIEF.md
# Shared packet buffer admission controller

This block keeps the accounting for one packet memory that several ports share. It stores no data. It keeps a byte count for the receive frames that each port holds in the memory and a byte count for the transmit traffic that each port has in flight. From these counts it derives the free space. Each port has a transmit allocation that is guaranteed but not reserved: receive traffic may borrow the part that transmit is not using, until transmit grows into it again. Each port also has a receive credit, in units of 8 bytes, that marks how many pending ingress bytes count as a fair share.

All traffic enters through one event channel, carrying at most one event per cycle. There are four event kinds: receive frame start, receive frame release, transmit frame start and transmit frame end. A receive frame start is admitted or refused, and the verdict appears on the next cycle. When free space falls below a programmable depletion threshold, the block drops whole stored receive frames. It does the same when the borrowed transmit share has to be handed back. Each drop is announced by a one-cycle drop command carrying the port and the frame length. The recommended settings are a depletion threshold of 1024 bytes and a receive credit of two maximum-size frames. The transmit allocation should exceed the transmit byte credit plus twice the maximum frame size plus 32 bytes.

Top module: `shared_buf_admit`

## Requirements
- R1: After reset, free_bytes equals MEM_BYTES, depleted is 0, and adm_valid and drop_valid are both 0.
- R2: A receive frame start (ev_kind 0) is accepted when two conditions hold: the port's stored-frame queue has fewer than QDEPTH entries, and used bytes plus the frame length plus the unused transmit guarantee of all ports is at most MEM_BYTES. On the next cycle adm_valid is 1 and adm_ok is 1, and free_bytes has dropped by the length.
- R3: A receive frame start that fails either condition is refused. adm_valid is 1 and adm_ok is 0, and free_bytes is unchanged.
- R4: A transmit frame start (ev_kind 2) is always counted: it adds its length to the port's transmit bytes. A transmit frame end (ev_kind 3) subtracts its length. Neither kind raises adm_valid.
- R5: A receive release (ev_kind 1) frees the oldest stored frame of the named port, by that frame's stored length. A release on a port with no stored frame has no effect on free_bytes.
- R6: depleted is 1 exactly when free_bytes is below cfg_deplete_thr.
- R7: A drop is issued in a cycle with ev_valid low when a frame is stored and either of two conditions holds: depleted is 1, or used bytes plus the unused transmit guarantee exceed MEM_BYTES. On the next cycle drop_valid is 1 with drop_port and drop_len, and free_bytes has grown by drop_len. Drops repeat on idle cycles while the condition lasts.
- R8: The dropped frame is the oldest head frame among ports whose receive bytes exceed 8 times their credit. If no port is over its credit, it is the oldest stored frame of any port.
- R9: A dropped frame is gone: its bytes are returned once, and a later release on that port frees the next stored frame, or nothing if none is left.
- R10: Byte counters saturate at zero. A transmit end longer than the port's transmit bytes leaves that count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | 0 receive start, 1 receive release, 2 transmit start, 3 transmit end |
| ev_port | input | PW | Port of the event |
| ev_len | input | LENW | Frame length in bytes (receive start, transmit start, transmit end) |
| cfg_deplete_thr | input | CW | Depletion threshold in bytes |
| cfg_tx_alloc | input | NPORTS*CW | Guaranteed transmit bytes per port, port p at bits p*CW |
| cfg_rx_credit | input | NPORTS*CRW | Receive credit per port in 8-byte units, port p at bits p*CRW |
| adm_valid | output | 1 | Verdict for the previous cycle's receive start |
| adm_ok | output | 1 | 1 accepted, 0 refused |
| drop_valid | output | 1 | Drop command |
| drop_port | output | PW | Port whose frame is dropped |
| drop_len | output | LENW | Length of the dropped frame |
| depleted | output | 1 | Free space below threshold |
| free_bytes | output | CW | Unused bytes in the memory, floored at zero |

## Verification
The assertions check four things on every cycle. An accepted frame never increases free space. A refused frame leaves free space untouched. A drop never reduces free space. A drop never shares a cycle with an event. The scenarios are needed for the rest, because those properties need a known history. That covers the choice of which frame is dropped (the over-credit port against the oldest frame overall), chains of drops that run while depletion lasts, reclaim of the transmit guarantee after a configuration change, the queue-full refusal, and releases that find no frame after a drop.

// File: rtl/shared_buf_admit.sv
module shared_buf_admit #(
  parameter int NPORTS    = 4,
  parameter int MEM_BYTES = 16384,
  parameter int LENW      = 14,
  parameter int QDEPTH    = 4,
  parameter int SW        = 16,
  localparam int PW  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int CW  = $clog2(MEM_BYTES + 1) + 1,
  localparam int CRW = CW - 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_valid,
  input  logic [1:0]             ev_kind,
  input  logic [PW-1:0]          ev_port,
  input  logic [LENW-1:0]        ev_len,
  input  logic [CW-1:0]          cfg_deplete_thr,
  input  logic [NPORTS*CW-1:0]   cfg_tx_alloc,
  input  logic [NPORTS*CRW-1:0]  cfg_rx_credit,
  output logic                   adm_valid,
  output logic                   adm_ok,
  output logic                   drop_valid,
  output logic [PW-1:0]          drop_port,
  output logic [LENW-1:0]        drop_len,
  output logic                   depleted,
  output logic [CW-1:0]          free_bytes
);
  localparam int QW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCW  = $clog2(QDEPTH + 1);
  localparam int SUMW = CW + $clog2(2 * NPORTS) + 1;
  localparam logic [SUMW-1:0] MEM_S = SUMW'(MEM_BYTES);
  localparam logic [1:0] K_RXS = 2'd0, K_RXR = 2'd1, K_TXS = 2'd2, K_TXE = 2'd3;

  logic [LENW-1:0] q_len   [NPORTS][QDEPTH];
  logic [SW-1:0]   q_stamp [NPORTS][QDEPTH];
  logic [QW-1:0]   rd_p [NPORTS];
  logic [QW-1:0]   wr_p [NPORTS];
  logic [QCW-1:0]  cnt  [NPORTS];
  logic [CW-1:0]   rx_occ [NPORTS];
  logic [CW-1:0]   tx_occ [NPORTS];
  logic [SW-1:0]   stamp_ctr;

  function automatic logic [CW-1:0] sat_add(logic [CW-1:0] a, logic [LENW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + (CW+1)'(b);
    return s[CW] ? '1 : s[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] sat_sub(logic [CW-1:0] a, logic [CW-1:0] b);
    return (a > b) ? a - b : '0;
  endfunction

  function automatic logic [QW-1:0] nxt(logic [QW-1:0] p);
    return (p == QW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [SUMW-1:0] used_sum, need_sum;
  logic            sel_valid, sel_over, cand_over;
  logic [PW-1:0]   sel_port;
  logic [SW-1:0]   sel_age, cand_age;

  always_comb begin
    used_sum  = '0;
    need_sum  = '0;
    sel_valid = 1'b0;
    sel_over  = 1'b0;
    sel_port  = '0;
    sel_age   = '0;
    cand_over = 1'b0;
    cand_age  = '0;
    for (int p = 0; p < NPORTS; p++) begin
      used_sum = used_sum + SUMW'(rx_occ[p]) + SUMW'(tx_occ[p]);
      if (cfg_tx_alloc[p*CW +: CW] > tx_occ[p])
        need_sum = need_sum + SUMW'(cfg_tx_alloc[p*CW +: CW] - tx_occ[p]);
      if (cnt[p] != '0) begin
        cand_over = rx_occ[p] > {cfg_rx_credit[p*CRW +: CRW], 3'b000};
        cand_age  = stamp_ctr - q_stamp[p][rd_p[p]];
        if (!sel_valid || (cand_over && !sel_over) ||
            (cand_over == sel_over && cand_age > sel_age)) begin
          sel_valid = 1'b1;
          sel_over  = cand_over;
          sel_port  = PW'(p);
          sel_age   = cand_age;
        end
      end
    end
  end

  assign free_bytes = (used_sum >= MEM_S) ? '0 : CW'(MEM_S - used_sum);
  assign depleted   = free_bytes < cfg_deplete_thr;

  wire owed      = (used_sum + need_sum) > MEM_S;
  wire do_drop   = !ev_valid && sel_valid && (depleted || owed);
  wire rxs       = ev_valid && ev_kind == K_RXS;
  wire room      = cnt[ev_port] != QCW'(QDEPTH);
  wire fits      = (used_sum + SUMW'(ev_len) + need_sum) <= MEM_S;
  wire accept    = rxs && room && fits;
  wire pop       = do_drop || (ev_valid && ev_kind == K_RXR && cnt[ev_port] != '0);
  wire [PW-1:0]   pop_port = do_drop ? sel_port : ev_port;
  wire [LENW-1:0] pop_len  = q_len[pop_port][rd_p[pop_port]];

  always_ff @(posedge clk) begin
    if (accept) begin
      q_len[ev_port][wr_p[ev_port]]   <= ev_len;
      q_stamp[ev_port][wr_p[ev_port]] <= stamp_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) begin
        rd_p[p]   <= '0;
        wr_p[p]   <= '0;
        cnt[p]    <= '0;
        rx_occ[p] <= '0;
        tx_occ[p] <= '0;
      end
      stamp_ctr  <= '0;
      adm_valid  <= 1'b0;
      adm_ok     <= 1'b0;
      drop_valid <= 1'b0;
      drop_port  <= '0;
      drop_len   <= '0;
    end else begin
      adm_valid  <= rxs;
      adm_ok     <= accept;
      drop_valid <= do_drop;
      if (do_drop) begin
        drop_port <= sel_port;
        drop_len  <= pop_len;
      end
      if (accept) begin
        wr_p[ev_port]   <= nxt(wr_p[ev_port]);
        cnt[ev_port]    <= cnt[ev_port] + 1'b1;
        rx_occ[ev_port] <= sat_add(rx_occ[ev_port], ev_len);
        stamp_ctr       <= stamp_ctr + 1'b1;
      end
      if (pop) begin
        rd_p[pop_port]   <= nxt(rd_p[pop_port]);
        cnt[pop_port]    <= cnt[pop_port] - 1'b1;
        rx_occ[pop_port] <= sat_sub(rx_occ[pop_port], CW'(pop_len));
      end
      if (ev_valid && ev_kind == K_TXS)
        tx_occ[ev_port] <= sat_add(tx_occ[ev_port], ev_len);
      if (ev_valid && ev_kind == K_TXE)
        tx_occ[ev_port] <= sat_sub(tx_occ[ev_port], CW'(ev_len));
    end
  end

  assert_accept_consumes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adm_valid && adm_ok) |-> free_bytes <= $past(free_bytes));

  assert_refuse_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adm_valid && !adm_ok) |-> free_bytes == $past(free_bytes));

  assert_drop_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid |-> free_bytes >= $past(free_bytes));

  assert_drop_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid |-> !$past(ev_valid));
endmodule

// File: tb/sim_shared_buf_admit.sv
module sim_shared_buf_admit;
  localparam int NP = 4, CW = 16, CRW = 13, LENW = 14;
  localparam int MEM = 16384;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [1:0] ev_port = '0;
  logic [LENW-1:0] ev_len = '0;
  logic [CW-1:0] thr = 16'd1024;
  logic [NP*CW-1:0] tx_alloc = '0;
  logic [NP*CRW-1:0] credit = '1;
  logic adm_valid, adm_ok, drop_valid, depleted;
  logic [1:0] drop_port;
  logic [LENW-1:0] drop_len;
  logic [CW-1:0] free_bytes;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  shared_buf_admit u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_port(ev_port), .ev_len(ev_len), .cfg_deplete_thr(thr),
    .cfg_tx_alloc(tx_alloc), .cfg_rx_credit(credit),
    .adm_valid(adm_valid), .adm_ok(adm_ok), .drop_valid(drop_valid),
    .drop_port(drop_port), .drop_len(drop_len), .depleted(depleted),
    .free_bytes(free_bytes));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ev(int kind, int port, int len);
    ev_valid = 1'b1;
    ev_kind  = 2'(kind);
    ev_port  = 2'(port);
    ev_len   = LENW'(len);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic rx_start(int port, int len, int exp_ok, int exp_free, string req);
    ev(0, port, len);
    chk(req, "adm_valid", int'(adm_valid), 1);
    chk(req, "adm_ok", int'(adm_ok), exp_ok);
    chk(req, "free_bytes", int'(free_bytes), exp_free);
  endtask

  task automatic set_alloc(int port, int val);
    tx_alloc[port*CW +: CW] = CW'(val);
  endtask

  task automatic t_reset_r1;
    chk("R1", "free_bytes", int'(free_bytes), MEM);
    chk("R1", "depleted", int'(depleted), 0);
    chk("R1", "adm_valid", int'(adm_valid), 0);
    chk("R1", "drop_valid", int'(drop_valid), 0);
  endtask

  task automatic t_accept_release_r2_r5;
    rx_start(0, 1500, 1, 14884, "R2");
    ev(1, 0, 0);
    chk("R5", "free after release", int'(free_bytes), MEM);
    ev(1, 0, 0);
    chk("R5", "release on empty port", int'(free_bytes), MEM);
  endtask

  task automatic t_tx_r4_r10;
    ev(2, 1, 4000);
    chk("R4", "adm_valid on tx start", int'(adm_valid), 0);
    chk("R4", "free after tx start", int'(free_bytes), 12384);
    ev(3, 1, 5000);
    chk("R10", "free after long tx end", int'(free_bytes), MEM);
    ev(2, 1, 100);
    chk("R10", "tx count floored at zero", int'(free_bytes), 16284);
    ev(3, 1, 100);
    chk("R4", "free after tx end", int'(free_bytes), MEM);
  endtask

  task automatic t_refuse_r3;
    set_alloc(2, 10000);
    @(negedge clk);
    rx_start(0, 6000, 1, 10384, "R2");
    rx_start(0, 500, 0, 10384, "R3");
    ev(1, 0, 0);
    chk("R5", "free after release", int'(free_bytes), MEM);
  endtask

  task automatic t_reclaim_r7;
    rx_start(0, 3000, 1, 13384, "R2");
    rx_start(1, 3000, 1, 10384, "R2");
    ev(2, 2, 8000);
    chk("R7", "no drop before depletion", int'(depleted), 0);
    ev(2, 2, 1500);
    chk("R6", "depleted below threshold", int'(depleted), 1);
    chk("R6", "free at depletion", int'(free_bytes), 884);
    @(negedge clk);
    chk("R7", "drop_valid", int'(drop_valid), 1);
    chk("R8", "oldest frame port", int'(drop_port), 0);
    chk("R7", "drop_len", int'(drop_len), 3000);
    chk("R7", "free after drop", int'(free_bytes), 3884);
    chk("R6", "depleted cleared", int'(depleted), 0);
    @(negedge clk);
    chk("R7", "drop stops", int'(drop_valid), 0);
    ev(3, 2, 9500);
    ev(1, 1, 0);
    chk("R9", "free after cleanup", int'(free_bytes), MEM);
    ev(1, 0, 0);
    chk("R9", "dropped frame not released again", int'(free_bytes), MEM);
    set_alloc(2, 0);
    @(negedge clk);
  endtask

  task automatic t_over_credit_r8;
    credit[1*CRW +: CRW] = CRW'(250);
    rx_start(0, 5000, 1, 11384, "R2");
    rx_start(1, 1500, 1, 9884, "R2");
    rx_start(1, 1500, 1, 8384, "R2");
    ev(2, 3, 7500);
    chk("R6", "depleted", int'(depleted), 1);
    @(negedge clk);
    chk("R8", "drop_valid", int'(drop_valid), 1);
    chk("R8", "over-credit port chosen", int'(drop_port), 1);
    chk("R8", "drop_len", int'(drop_len), 1500);
    chk("R7", "free after drop", int'(free_bytes), 2384);
    @(negedge clk);
    chk("R7", "single drop", int'(drop_valid), 0);
    ev(3, 3, 7500);
    ev(1, 0, 0);
    ev(1, 1, 0);
    chk("R9", "next p1 frame released", int'(free_bytes), MEM);
    ev(1, 1, 0);
    chk("R9", "p1 empty after drop", int'(free_bytes), MEM);
    credit = '1;
    @(negedge clk);
  endtask

  task automatic t_chain_r7;
    rx_start(0, 4000, 1, 12384, "R2");
    rx_start(1, 4000, 1, 8384, "R2");
    rx_start(2, 4000, 1, 4384, "R2");
    ev(2, 3, 8000);
    chk("R6", "free floored", int'(free_bytes), 0);
    @(negedge clk);
    chk("R7", "first drop", int'(drop_valid), 1);
    chk("R8", "first drop port", int'(drop_port), 0);
    chk("R7", "free after first drop", int'(free_bytes), 384);
    @(negedge clk);
    chk("R7", "second drop", int'(drop_valid), 1);
    chk("R8", "second drop port", int'(drop_port), 1);
    chk("R7", "second drop len", int'(drop_len), 4000);
    chk("R7", "free after second drop", int'(free_bytes), 4384);
    @(negedge clk);
    chk("R7", "chain ends", int'(drop_valid), 0);
    ev(1, 0, 0);
    ev(1, 1, 0);
    chk("R9", "releases after drops ignored", int'(free_bytes), 4384);
    ev(1, 2, 0);
    ev(3, 3, 8000);
    chk("R9", "free after cleanup", int'(free_bytes), MEM);
  endtask

  task automatic t_owed_r7;
    rx_start(1, 5000, 1, 11384, "R2");
    set_alloc(2, 12000);
    @(negedge clk);
    chk("R7", "owed drop without depletion", int'(drop_valid), 1);
    chk("R7", "owed drop port", int'(drop_port), 1);
    chk("R7", "free after owed drop", int'(free_bytes), MEM);
    set_alloc(2, 0);
    @(negedge clk);
  endtask

  task automatic t_full_r3;
    for (int i = 0; i < 4; i++) rx_start(0, 100, 1, MEM - 100 * (i + 1), "R2");
    rx_start(0, 100, 0, 15984, "R3");
    for (int i = 0; i < 4; i++) ev(1, 0, 0);
    chk("R5", "free after queue drained", int'(free_bytes), MEM);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_accept_release_r2_r5();
    t_tx_r4_r10();
    t_refuse_r3();
    t_reclaim_r7();
    t_over_credit_r8();
    t_chain_r7();
    t_owed_r7();
    t_full_r3();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule